// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out shift register. It runs as synchronous logic on a fast system clock. It treats two slow external clock lines, an active-low load line and a serial data line as asynchronous inputs. Each of these passes through a synchroniser. The two clock lines are then ORed, and a rising edge of that combined clock moves every stage up one place while the serial bit enters the bottom stage. Because the lines are ORed, holding either clock line high blocks the other, so each line can act as an active-low enable.

While the load line is low, the register follows the parallel inputs and ignores every clock edge. The top stage and its inverse are the serial outputs, so a loaded word comes out with its highest bit first. The block is used wherever a slow parallel word must be turned into a bit stream clocked from one of two sources.

Top module: `piso_shifter`

## Requirements
- R1: A low `rstN` at a system clock edge clears all stages and the edge history, so `serOut` is 0 and `serOutN` is 1.
- R2: While `loadN` is low, the register takes `parIn` on every system clock, and it keeps following `parIn` if `parIn` changes while `loadN` stays low.
- R3: While `loadN` is low, no clock edge shifts the register. If `loadN` is released while a clock line is already high, no shift follows.
- R4: A shift happens once for each rising edge of the OR of `clkA` and `clkB`, whichever line makes the edge.
- R5: While one clock line is held high, pulses on the other line cause no shift.
- R6: A shift moves bit i to bit i+1 for i = 0..6 and captures `serialIn` into bit 0. After a load, `parIn[7]` appears first, then `parIn[6]` and the lower bits in turn.
- R7: `serOut` is bit 7 of the register and `serOutN` is always its inverse.
- R8: Raising one clock line while the other is low causes one extra shift. Raising it while the other line is high causes none.
- R9: With `loadN` high and both clock lines low, the register holds its contents.
- R10: Each input passes two synchroniser flops. A change driven between system edges shows at the outputs after the third following system clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkA | input | 1 | External shift clock / enable line A (asynchronous) |
| clkB | input | 1 | External shift clock / enable line B (asynchronous) |
| loadN | input | 1 | Active-low level-sensitive parallel load (asynchronous) |
| serialIn | input | 1 | Serial data into bit 0 (asynchronous) |
| parIn | input | 8 | Parallel data word; bit 7 leaves first |
| serOut | output | 1 | Top stage of the register |
| serOutN | output | 1 | Inverse of the top stage |

## Verification
Two functions can fall in the same system cycle: a load and a combined-clock edge. The bench provokes this by pulsing a clock line while `loadN` is low, and by releasing `loadN` while a clock line is already high. In both cases the output must equal the loaded word with no shift. The second collision is between the gating function and shifting. It is provoked by raising one clock line while the other is low, and then while the other is high, and the reference queue model decides whether exactly one shift or none is expected.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Strobes from the control path to the datapath, valid for one system cycle
  typedef struct packed {
    logic load;     // copy the parallel word this cycle
    logic shift;    // move one place up this cycle
    logic serBit;   // synchronised serial input aligned with shift
    logic combNow;  // synchronised OR of both clock lines
  } piso_strobe_t;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int               STAGES    = 2,
  parameter int               WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= RESET_VAL;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkA,
  input  logic         clkB,
  input  logic         loadN,
  input  logic         serialIn,
  output piso_strobe_t strobes
);
  localparam int NUM_LINES = 4;
  // Bit order: {clkA, clkB, serialIn, loadN}; loadN resets inactive (high)
  localparam logic [NUM_LINES-1:0] LINE_RESET = 4'b0001;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic                 combNow;
  logic                 combPrev;
  logic                 combRise;

  assign rawLines = {clkA, clkB, serialIn, loadN};

  piso_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (NUM_LINES),
    .RESET_VAL(LINE_RESET)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawLines),
    .syncOut(syncLines)
  );

  assign combNow = syncLines[3] | syncLines[2];

  // History tracks the combined clock even while loading
  always_ff @(posedge clk) begin
    if (!rstN) combPrev <= 1'b0;
    else       combPrev <= combNow;
  end

  assign combRise = combNow & ~combPrev;

  always_comb begin
    strobes.load    = ~syncLines[0];
    strobes.shift   = combRise & syncLines[0];
    strobes.serBit  = syncLines[1];
    strobes.combNow = combNow;
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  piso_strobe_t     strobes,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regQ
);
  always_ff @(posedge clk) begin
    if (!rstN)              regQ <= '0;
    else if (strobes.load)  regQ <= parIn;
    else if (strobes.shift) regQ <= {regQ[WIDTH-2:0], strobes.serBit};
  end
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkA,
  input  logic             clkB,
  input  logic             loadN,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN
);
  localparam int TOP = WIDTH - 1;

  piso_strobe_t     strobes;
  logic [WIDTH-1:0] regQ;

  piso_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkA    (clkA),
    .clkB    (clkB),
    .loadN   (loadN),
    .serialIn(serialIn),
    .strobes (strobes)
  );

  piso_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .parIn  (parIn),
    .regQ   (regQ)
  );

  assign serOut  = regQ[TOP];
  assign serOutN = ~regQ[TOP];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] regQ,
  input piso_strobe_t     strobes
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> regQ == '0);

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> regQ == $past(parIn));

  // R3
  load_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !strobes.shift);

  // R4
  edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> strobes.combNow && !$past(strobes.combNow));

  // R6
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> regQ == {$past(regQ[WIDTH-2:0]), $past(strobes.serBit)});

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load && !strobes.shift |=> $stable(regQ));
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .parIn  (parIn),
  .regQ   (regQ),
  .strobes(strobes)
);

// File: tb/test_piso_shifter.sv
module test_piso_shifter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       clkA;
  logic       clkB;
  logic       loadN;
  logic       serialIn;
  logic [7:0] parIn;
  logic       serOut;
  logic       serOutN;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model;   // reference register
  bit modelQ[$];       // reference stream: front is the next bit out

  always #10ns clk = ~clk;   // 50 MHz

  piso_shifter i_piso_shifter (
    .clk(clk), .rstN(rstN), .clkA(clkA), .clkB(clkB), .loadN(loadN),
    .serialIn(serialIn), .parIn(parIn), .serOut(serOut), .serOutN(serOutN)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input string req);
    checks++;
    if (serOut !== model[7] || serOutN !== ~model[7]) begin
      errors++;
      $display("FAIL %s: serOut=%b serOutN=%b expected %b %b",
               req, serOut, serOutN, model[7], ~model[7]);
    end
  endtask

  task automatic modelLoad(input logic [7:0] w);
    model = w;
    modelQ.delete();
    for (int i = 7; i >= 0; i--) modelQ.push_back(w[i]);
  endtask

  task automatic modelShift(input bit d);
    model = {model[6:0], d};
    void'(modelQ.pop_front());
    modelQ.push_back(d);
  endtask

  task automatic pulse(input bit useB, input bit d, input string req);
    serialIn = d;
    if (useB) clkB = 1'b1; else clkA = 1'b1;
    waitN(4);
    modelShift(d);
    checkOut(req);
    checks++;
    if (serOut !== modelQ[0]) begin
      errors++;
      $display("FAIL R6: stream bit %b expected %b", serOut, modelQ[0]);
    end
    if (useB) clkB = 1'b0; else clkA = 1'b0;
    waitN(4);
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkA = 1'b0; clkB = 1'b0; loadN = 1'b1;
    serialIn = 1'b0; parIn = 8'h00;
    modelLoad(8'h00);
    waitN(4);
    rstN = 1'b1;
    waitN(2);
    checkOut("R1 reset state");

    // R2: continuous load follows parIn
    loadN = 1'b0; parIn = 8'hA5;
    waitN(4); modelLoad(8'hA5); checkOut("R2 load A5");
    parIn = 8'h3C;
    waitN(4); modelLoad(8'h3C); checkOut("R2 load follows 3C");
    parIn = 8'h96;
    waitN(4); modelLoad(8'h96); checkOut("R2 load follows 96");

    // R3: edges during load do nothing
    clkA = 1'b1; waitN(4); checkOut("R3 clkA edge in load");
    clkA = 1'b0; clkB = 1'b1; waitN(4); checkOut("R3 clkB edge in load");
    clkB = 1'b0; waitN(4);
    loadN = 1'b1; waitN(4); checkOut("R9 after load release");

    // R6/R4: drain the word, alternating clock lines, P7 first
    for (int i = 0; i < 8; i++) begin
      pulse(i[0], (8'b1100_1010 >> i) & 1'b1, "R6 R4 shift drain");
    end

    // R10: exact latency of one shift
    loadN = 1'b0; parIn = 8'h80; waitN(4); modelLoad(8'h80);
    loadN = 1'b1; waitN(4);
    serialIn = 1'b0; clkA = 1'b1;
    waitN(2); checkOut("R10 unchanged after two edges");
    waitN(1); modelShift(1'b0); checkOut("R10 changed after third edge");
    clkA = 1'b0; waitN(4);

    // R5: clkB held high blocks clkA
    loadN = 1'b0; parIn = 8'hF0; waitN(4); modelLoad(8'hF0);
    loadN = 1'b1; waitN(4);
    clkB = 1'b1; serialIn = 1'b0; waitN(4);
    modelShift(1'b0); checkOut("R8 raising clkB with clkA low shifts");
    for (int i = 0; i < 3; i++) begin
      clkA = 1'b1; waitN(4); clkA = 1'b0; waitN(4);
      checkOut("R5 clkA blocked by clkB high");
    end
    // R8 hazard: releasing gate high->low no shift, then raising with other low shifts
    clkB = 1'b0; waitN(4); checkOut("R9 gate fall no shift");
    serialIn = 1'b1; clkA = 1'b1; waitN(4);
    modelShift(1'b1); checkOut("R4 clkA edge shifts");
    clkB = 1'b1; waitN(4); checkOut("R8 raising clkB with clkA high no shift");
    clkA = 1'b0; waitN(4); checkOut("R5 hold while clkB high");
    clkB = 1'b0; waitN(4); checkOut("R9 both low hold");

    // R3: release load while clock already high
    loadN = 1'b0; parIn = 8'h5A; waitN(4); modelLoad(8'h5A);
    clkA = 1'b1; waitN(4);
    loadN = 1'b1; waitN(6); checkOut("R3 release with clkA high no shift");
    clkA = 1'b0; waitN(4); checkOut("R3 clkA fall no shift");

    // R9: long hold with both lines low
    for (int i = 0; i < 4; i++) begin
      serialIn = i[0];
      waitN(5); checkOut("R9 idle hold");
    end

    // R7: complement on every bit of a fresh word
    loadN = 1'b0; parIn = 8'h69; waitN(4); modelLoad(8'h69);
    loadN = 1'b1; waitN(4);
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, "R7 complement B shifts");

    // R1: reset mid-stream
    loadN = 1'b0; parIn = 8'hFF; waitN(4); modelLoad(8'hFF);
    loadN = 1'b1; waitN(4); checkOut("R2 load FF");
    rstN = 1'b0; waitN(2); rstN = 1'b1; modelLoad(8'h00);
    waitN(1); checkOut("R1 reset clears");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule